// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block turns one memory instruction issued by a group of 32 parallel lanes into the smallest set of aligned memory transactions that serves it. Each lane supplies an active bit and a byte address. The request also carries a shared access size of 4, 8 or 16 bytes and a flag that picks the caching mode. In the cached mode every transaction covers one 128-byte aligned segment. In the second-level-only mode every transaction covers one 32-byte aligned segment, which cuts over-fetch when lane addresses are scattered.

After a request is accepted, the block hands out transactions one per cycle over a valid/ready handshake. Each transaction gives a segment base address and the mask of lanes that the segment serves. The leading lane of each transaction is the lowest-numbered active lane that has not yet been served. When the last transaction has been taken, a one-cycle done pulse reports how many transactions the request needed and how many instruction replays that implies, which is the count minus one. The block does not move data and does not model the caches.

Top module: `warp_coalescer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears itself. After that edge `txn_valid` and `done` are 0 and `req_ready` is 1.
- R2: With `req_l2only` = 0, each transaction's `txn_base` is the leading lane's address with its low 7 bits cleared. `txn_mask` holds every unserved active lane whose address lies in that 128-byte segment.
- R3: With `req_l2only` = 1, each transaction's `txn_base` is the leading lane's address with its low 5 bits cleared. `txn_mask` holds every unserved active lane in that 32-byte segment.
- R4: A request produces exactly one transaction for each distinct segment touched by its active lanes. The `req_size` encoding is 0 = 4 bytes, 1 = 8 bytes and 2 or 3 = 16 bytes. Lane addresses are aligned down to the access size. In 128-byte mode, 32 active lanes at consecutive aligned addresses give 1, 2 or 4 transactions for codes 0, 1 and 2.
- R5: Transactions come out ordered by their leading lane. The leading lane is the lowest-numbered active lane not yet covered by an earlier transaction.
- R6: Inactive lanes never appear in any `txn_mask`, and their addresses create no transaction.
- R7: A request with no active lanes produces no transaction. `done` is high in the cycle right after acceptance, with `done_count` = 0 and `done_replays` = 0.
- R8: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_base` and `txn_mask` stay unchanged into the next cycle.
- R9: `req_ready` is 0 while any transaction of the current request is still pending. `req_valid` has no effect during that time.
- R10: `done` is high for exactly one cycle, in the cycle after the final transaction handshake. At that point `done_count` equals the number of transactions and `done_replays` equals that number minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can take a request |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_size | input | 2 | Access size code: 0 = 4 B, 1 = 8 B, 2/3 = 16 B |
| req_l2only | input | 1 | 1 selects 32-byte segments, 0 selects 128-byte segments |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | The consumer takes the transaction |
| txn_base | output | ADDR_W | Segment-aligned base address |
| txn_mask | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle end-of-request pulse |
| done_count | output | CNT_W | Transactions used by the request (0 to 32) |
| done_replays | output | CNT_W | Replays: count minus one, or 0 for an empty request |

## Verification
The assertions rely on two assumptions. The consumer is allowed to stall `txn_ready` for any length of time. Lane addresses are naturally aligned to the access size, so no lane straddles a segment. The bench draws every random address as a multiple of the access size inside a narrow window, so that segments are shared often. It stalls `txn_ready` at random and keeps offering junk requests while the block is busy. Directed cases cover the empty request, a request that needs all 32 transactions in reverse order, and the contiguous 1/2/4 transaction targets in both modes.

// File: rtl/wc_pkg.sv
// Package: shared types and helpers for the warp memory access coalescer.
// Assumes size codes 2 and 3 both mean 16-byte accesses.
package wc_pkg;

    typedef enum logic [1:0] {
        ACC_4B  = 2'd0,
        ACC_8B  = 2'd1,
        ACC_16B = 2'd2,
        ACC_16X = 2'd3
    } acc_size_e;

    // Number of low address bits covered by one access of the given size.
    function automatic int unsigned size_lsbs(input acc_size_e sz);
        case (sz)
            ACC_4B:  return 2;
            ACC_8B:  return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/wc_req_store.sv
// Request store: captures the lane addresses (aligned down to the access
// size), the cache mode and the set of lanes still waiting for service.
// Assumes load is only raised while no lane is pending.
module wc_req_store
    import wc_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [LANES-1:0]          load_active,
    input  logic [LANES*ADDR_W-1:0]   load_addr,
    input  logic [1:0]                load_size,
    input  logic                      load_l2,
    input  logic [LANES-1:0]          served,
    output logic [LANES-1:0]          pend,
    output logic [LANES*ADDR_W-1:0]   addr_q,
    output logic                      l2_q
);

    logic [ADDR_W-1:0] size_keep;

    // Keep-mask that clears the address bits below the access size.
    always_comb begin
        size_keep = ~((ADDR_W'(1) << size_lsbs(acc_size_e'(load_size))) - ADDR_W'(1));
    end

    // Pending lanes: loaded from the active bits, then cleared as served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (load) begin
            pend <= load_active;
        end else begin
            pend <= pend & ~served;
        end
    end

    // Address and mode capture; these need no reset since pend gates them.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (load) begin
                    addr_q[g*ADDR_W +: ADDR_W] <= load_addr[g*ADDR_W +: ADDR_W] & size_keep;
                end
            end
        end
    endgenerate

    // Cache mode register for the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2_q <= 1'b0;
        end else if (load) begin
            l2_q <= load_l2;
        end
    end

endmodule

// File: rtl/wc_leader.sv
// Leader finder: returns the index of the lowest set bit of the pending
// mask. Assumes nothing about the mask; found is 0 when it is empty.
module wc_leader #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    // Scan from the top so the lowest set lane wins.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wc_seg_match.sv
// Segment matcher: forms the segment base of the leading lane for the
// current cache mode and marks every pending lane inside that segment.
// Assumes lane addresses do not straddle a segment.
module wc_seg_match #(
    parameter int LANES       = 32,
    parameter int ADDR_W      = 32,
    parameter int SEG_L1_LOG2 = 7,
    parameter int SEG_L2_LOG2 = 5,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES*ADDR_W-1:0] addr_q,
    input  logic [LANES-1:0]        pend,
    input  logic [IDX_W-1:0]        lead_idx,
    input  logic                    l2_q,
    output logic [ADDR_W-1:0]       base,
    output logic [LANES-1:0]        mask
);

    localparam logic [ADDR_W-1:0] OFF_L1 = (ADDR_W'(1) << SEG_L1_LOG2) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_L2 = (ADDR_W'(1) << SEG_L2_LOG2) - ADDR_W'(1);

    logic [ADDR_W-1:0] seg_keep;

    // Choose the segment size and derive the leader's segment base.
    always_comb begin
        seg_keep = l2_q ? ~OFF_L2 : ~OFF_L1;
        base     = addr_q[lead_idx*ADDR_W +: ADDR_W] & seg_keep;
    end

    // One comparator per lane against the leader's segment.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_cmp
            assign mask[g] = pend[g] &&
                             ((addr_q[g*ADDR_W +: ADDR_W] & seg_keep) == base);
        end
    endgenerate

endmodule

// File: rtl/warp_coalescer.sv
// Top: accepts a 32-lane request, issues one aligned transaction per cycle
// over valid/ready, and pulses done with the transaction and replay counts.
// Assumes naturally aligned lane addresses; a new request waits until the
// previous one has fully drained.
module warp_coalescer #(
    parameter int LANES       = 32,
    parameter int ADDR_W      = 32,
    parameter int SEG_L1_LOG2 = 7,
    parameter int SEG_L2_LOG2 = 5,
    localparam int IDX_W = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_l2only,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [LANES-1:0]        txn_mask,
    output logic                    done,
    output logic [CNT_W-1:0]        done_count,
    output logic [CNT_W-1:0]        done_replays
);

    logic [LANES-1:0]        pend;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic                    l2_q;
    logic [IDX_W-1:0]        lead_idx;
    logic                    lead_found;
    logic [LANES-1:0]        seg_mask;
    logic [ADDR_W-1:0]       seg_base;
    logic                    accept;
    logic                    fire;
    logic                    last_fire;
    logic [CNT_W-1:0]        txn_cnt;
    logic [LANES-1:0]        served;

    // Handshake decode for both sides.
    always_comb begin
        req_ready = ~lead_found;
        accept    = req_valid & req_ready;
        txn_valid = lead_found;
        txn_base  = seg_base;
        txn_mask  = seg_mask;
        fire      = txn_valid & txn_ready;
        last_fire = fire & ((pend & ~seg_mask) == '0);
        served    = fire ? seg_mask : '0;
    end

    wc_req_store #(
        .LANES (LANES),
        .ADDR_W(ADDR_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_active(req_active),
        .load_addr  (req_addr),
        .load_size  (req_size),
        .load_l2    (req_l2only),
        .served     (served),
        .pend       (pend),
        .addr_q     (addr_q),
        .l2_q       (l2_q)
    );

    wc_leader #(
        .LANES(LANES)
    ) i_leader (
        .pend (pend),
        .idx  (lead_idx),
        .found(lead_found)
    );

    wc_seg_match #(
        .LANES      (LANES),
        .ADDR_W     (ADDR_W),
        .SEG_L1_LOG2(SEG_L1_LOG2),
        .SEG_L2_LOG2(SEG_L2_LOG2)
    ) i_match (
        .addr_q  (addr_q),
        .pend    (pend),
        .lead_idx(lead_idx),
        .l2_q    (l2_q),
        .base    (seg_base),
        .mask    (seg_mask)
    );

    // Transaction counter for the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_cnt <= '0;
        end else if (accept) begin
            txn_cnt <= '0;
        end else if (fire) begin
            txn_cnt <= txn_cnt + CNT_W'(1);
        end
    end

    // Done pulse with final counts, one cycle after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            done_count   <= '0;
            done_replays <= '0;
        end else if (accept && (req_active == '0)) begin
            done         <= 1'b1;
            done_count   <= '0;
            done_replays <= '0;
        end else if (last_fire) begin
            done         <= 1'b1;
            done_count   <= txn_cnt + CNT_W'(1);
            done_replays <= txn_cnt;
        end else begin
            done         <= 1'b0;
        end
    end

endmodule

// File: rtl/wc_checker.sv
// Checker: protocol and result properties of the coalescer, bound to the
// top. Assumes the consumer may stall txn_ready arbitrarily.
module wc_checker #(
    parameter int LANES       = 32,
    parameter int ADDR_W      = 32,
    parameter int SEG_L1_LOG2 = 7,
    parameter int SEG_L2_LOG2 = 5,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_base,
    input logic [LANES-1:0]  txn_mask,
    input logic              done,
    input logic [CNT_W-1:0]  done_count,
    input logic [CNT_W-1:0]  done_replays,
    input logic              l2_q
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> !txn_valid && !done && req_ready);

    assert_l1_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !l2_q |-> txn_base[SEG_L1_LOG2-1:0] == '0);

    assert_l2_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_base[SEG_L2_LOG2-1:0] == '0);

    assert_served_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready |=> !txn_valid || ((txn_mask & $past(txn_mask)) == '0));

    assert_mask_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_mask != '0);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_mask));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    assert_replays_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= CNT_W'(LANES)) &&
                 (done_replays == ((done_count == '0) ? '0 : done_count - CNT_W'(1))));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !(req_valid && req_ready) |=> !done);

endmodule

bind warp_coalescer wc_checker #(
    .LANES      (LANES),
    .ADDR_W     (ADDR_W),
    .SEG_L1_LOG2(SEG_L1_LOG2),
    .SEG_L2_LOG2(SEG_L2_LOG2)
) i_wc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .txn_valid   (txn_valid),
    .txn_ready   (txn_ready),
    .txn_base    (txn_base),
    .txn_mask    (txn_mask),
    .done        (done),
    .done_count  (done_count),
    .done_replays(done_replays),
    .l2_q        (l2_q)
);

// File: tb/test_warp_coalescer.sv
// Bench: directed corner cases plus seeded random requests, checked
// against a reference transaction list computed by bench functions.
module test_warp_coalescer;

    localparam int LANES  = 32;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES-1:0]        req_active = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [1:0]              req_size = '0;
    logic                    req_l2only = 1'b0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_base;
    logic [LANES-1:0]        txn_mask;
    logic                    done;
    logic [CNT_W-1:0]        done_count;
    logic [CNT_W-1:0]        done_replays;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] lane_addr [LANES];
    logic [31:0] exp_base  [LANES];
    logic [31:0] exp_mask  [LANES];
    int          exp_n;

    always #4 clk = ~clk;

    warp_coalescer i_warp_coalescer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr),
        .req_size(req_size), .req_l2only(req_l2only),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_mask(txn_mask),
        .done(done), .done_count(done_count), .done_replays(done_replays)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: list of segments in leader order for the current lanes.
    function automatic void build_exp(input logic [31:0] act, input int sz, input bit l2);
        logic [31:0] pend;
        logic [31:0] keep_sz;
        logic [31:0] keep_seg;
        pend     = act;
        keep_sz  = ~((32'd4 << sz) - 32'd1);
        keep_seg = l2 ? ~32'd31 : ~32'd127;
        exp_n    = 0;
        while (pend != 0) begin
            int lead = 0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
            exp_base[exp_n] = lane_addr[lead] & keep_sz & keep_seg;
            exp_mask[exp_n] = '0;
            for (int i = 0; i < LANES; i++)
                if (pend[i] && ((lane_addr[i] & keep_sz & keep_seg) == exp_base[exp_n]))
                    exp_mask[exp_n][i] = 1'b1;
            pend = pend & ~exp_mask[exp_n];
            exp_n++;
        end
    endfunction

    // Issue one request and consume its transactions with random stalls.
    task automatic run_req(input logic [31:0] act, input int sz, input bit l2,
                           input int stall_pct, input string tag);
        int idx = 0;
        int guard = 0;
        bit prev_stall = 1'b0;
        logic [31:0] prev_base = '0;
        logic [31:0] prev_mask = '0;
        build_exp(act, sz, l2);
        @(negedge clk);
        check(req_ready === 1'b1, "R9", {tag, " ready when idle"}, 32'(req_ready), 32'd1);
        req_valid  = 1'b1;
        req_active = act;
        req_size   = 2'(sz);
        req_l2only = l2;
        for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = lane_addr[i];
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (done === 1'b1) begin
                check(!txn_valid, "R10", {tag, " no txn at done"}, 32'(txn_valid), 32'd0);
                check(idx == exp_n, "R4", {tag, " txns taken"}, 32'(idx), 32'(exp_n));
                check(done_count == CNT_W'(exp_n), "R10", {tag, " done_count"},
                      32'(done_count), 32'(exp_n));
                check(done_replays == CNT_W'((exp_n == 0) ? 0 : exp_n - 1), "R10",
                      {tag, " done_replays"}, 32'(done_replays),
                      32'((exp_n == 0) ? 0 : exp_n - 1));
                req_valid = 1'b0;
                txn_ready = 1'b0;
                break;
            end
            if (!txn_valid) begin
                check(1'b0, "R4", {tag, " txn missing before done"}, 32'(idx), 32'(exp_n));
                break;
            end
            if (prev_stall) begin
                check(txn_base == prev_base && txn_mask == prev_mask, "R8",
                      {tag, " stall hold"}, txn_base, prev_base);
            end
            if (idx < exp_n) begin
                check(txn_base == exp_base[idx], l2 ? "R3 R5" : "R2 R5",
                      {tag, " base"}, txn_base, exp_base[idx]);
                check(txn_mask == exp_mask[idx], "R2 R6", {tag, " mask"},
                      txn_mask, exp_mask[idx]);
            end else begin
                check(1'b0, "R4", {tag, " extra txn"}, 32'(idx), 32'(exp_n));
            end
            check(req_ready === 1'b0, "R9", {tag, " busy not ready"}, 32'(req_ready), 32'd0);
            // Offer a junk request while busy; it must be ignored.
            req_valid  = ($urandom_range(0, 1) == 1);
            req_active = '1;
            for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = $urandom;
            txn_ready  = ($urandom_range(0, 99) >= stall_pct);
            prev_stall = !txn_ready;
            prev_base  = txn_base;
            prev_mask  = txn_mask;
            if (txn_ready) idx++;
            @(negedge clk);
            guard++;
            if (guard > 400) begin
                check(1'b0, "R10", {tag, " request timeout"}, 32'(idx), 32'(exp_n));
                break;
            end
        end
        @(negedge clk);
        check(done === 1'b0, "R10", {tag, " done one cycle"}, 32'(done), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        check(txn_valid === 1'b0, "R1", "txn_valid after reset", 32'(txn_valid), 32'd0);
        check(done === 1'b0, "R1", "done after reset", 32'(done), 32'd0);
        check(req_ready === 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);

        // R4: contiguous aligned full requests in 128-byte mode: 1/2/4
        for (int sz = 0; sz < 3; sz++) begin
            for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h0001_0000 + 32'(i * (4 << sz));
            run_req('1, sz, 1'b0, 30, "contig128");
            check(exp_n == (1 << sz), "R4", "contig target", 32'(exp_n), 32'(1 << sz));
        end
        // R3: same contiguous 4-byte pattern in 32-byte mode gives 4
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h0002_0000 + 32'(i * 4);
        run_req('1, 0, 1'b1, 30, "contig32");

        // R7: no active lanes
        run_req('0, 0, 1'b0, 0, "empty");

        // R5: reverse layout, one segment per lane, 32 transactions
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h0004_0000 + 32'((LANES - 1 - i) * 128);
        run_req('1, 2, 1'b0, 20, "reverse");

        // R6: sparse lanes, inactive lanes point at wild addresses
        for (int i = 0; i < LANES; i++) lane_addr[i] = (i % 3 == 0) ? 32'h0008_0040 : 32'hFFFF_FF00 - 32'(i * 256);
        run_req(32'h4924_9249, 0, 1'b0, 10, "sparse");

        // R4: all lanes at one address
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h0000_0F10;
        run_req('1, 1, 1'b1, 0, "same");

        // R2 R3 R5 random: addresses aligned to the size in a narrow window
        for (int t = 0; t < 60; t++) begin
            int sz;
            bit l2;
            logic [31:0] act;
            logic [31:0] win;
            sz  = $urandom_range(0, 2);
            l2  = $urandom_range(0, 1);
            act = ($urandom_range(0, 7) == 0) ? '1 : $urandom;
            win = {$urandom_range(0, 255), 12'h000};
            for (int i = 0; i < LANES; i++)
                lane_addr[i] = win + 32'($urandom_range(0, 63) * (4 << sz));
            run_req(act, sz, l2, 40, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule